// File: doc/BRIEF.md
# USB Host Attach/Detach Detector

This block watches the single-ended levels of the two USB data lines on the host side. It decides when a device has been plugged in and when it has been removed. Before any timing logic sees the raw line inputs, they pass through a two-flop synchronizer. A qualification timer then requires a line pattern to persist for a fixed window of 2.5 microseconds. The window is derived from the clock frequency parameter as ceil(2.5 us x f), which is 313 cycles at 125 MHz. A glitch shorter than the window changes nothing.

On a qualified attach, the block does three things. It sets a connection-status bit. It latches the bus speed from whichever line the device pull-up holds high. It raises a connection-change flag. If the attach happens while the bus is suspended, a resume flag is raised as well. Each flag drives an interrupt output only when its enable is set. Software clears a flag by writing a one to it. A soft-reset input clears the flags and freezes the timers until it is released. Removal is declared only after both lines stay low for an unbroken window.

Top module: `usbh_attach_detect`

## Requirements
- R1: While disconnected, a pattern with exactly one line high must persist for THRESH = ceil(2.5e-6 x CLK_HZ) consecutive clock cycles at the inputs before `conn_o` becomes 1. A pattern held THRESH-1 cycles leaves `conn_o` at 0. With the pattern applied before clock edge 0, `conn_o` rises after edge THRESH+1 (two synchronizer flops plus the timer).
- R2: On a qualified attach, `speed_o` is loaded in the same edge that `conn_o` rises. It is loaded with 1 (full speed) when `dp_i` is the high line and with 0 (low speed) when `dm_i` is the high line. It does not change while `conn_o` stays 1.
- R3: While connected, both lines low for THRESH consecutive cycles clear `conn_o`. Both lines low for THRESH-1 cycles leave it at 1.
- R4: Any break in the qualifying pattern before THRESH cycles restarts the count from zero. This includes a one-cycle interruption and a swap between the dp-high and dm-high patterns.
- R5: A qualified attach sets `conn_flag_o`. `conn_irq_o` equals `conn_flag_o` AND `conn_ie_i`.
- R6: A qualified attach while `suspend_i` = 1 also sets `wake_flag_o`. An attach with `suspend_i` = 0 does not set it. `wake_irq_o` equals `wake_flag_o` AND `wake_ie_i`.
- R7: A 1 on `conn_clr_i` or `wake_clr_i` clears the matching flag at the next edge. If the flag's set event occurs in the same cycle, the flag ends up set.
- R8: While `soft_rst_i` = 1, both flags are cleared and both timers are held at zero, so `conn_o` cannot change. After release, qualification restarts from zero. `conn_o` and `speed_o` keep their values through a soft reset.
- R9: After `rst_i`, `conn_o`, `speed_o` and both flags are 0.
- R10: Both lines high counts as neither attach nor detach, however long it is held. A detach sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Soft reset: clears flags, holds timers |
| dp_i | input | 1 | Raw D+ level |
| dm_i | input | 1 | Raw D- level |
| suspend_i | input | 1 | Bus is in suspend state |
| conn_ie_i | input | 1 | Connection interrupt enable |
| wake_ie_i | input | 1 | Resume interrupt enable |
| conn_clr_i | input | 1 | Write-one-to-clear for the connection flag |
| wake_clr_i | input | 1 | Write-one-to-clear for the resume flag |
| conn_o | output | 1 | Connection status |
| speed_o | output | 1 | Detected speed, 1 full, 0 low |
| conn_flag_o | output | 1 | Connection-change flag |
| wake_flag_o | output | 1 | Resume flag |
| conn_irq_o | output | 1 | Gated connection interrupt |
| wake_irq_o | output | 1 | Gated resume interrupt |

## Verification
An off-by-one in the qualification counter or the synchronizer depth shows up directly as `conn_o` flipping for a pulse of THRESH-1 cycles, or staying put for one of THRESH. The bench sweeps pulse lengths around THRESH for both attach polarities and for removal, so such a fault appears within one window of about 315 cycles. A counter that fails to restart lets split patterns qualify, and `conn_o` rises where it must stay low. A wrong priority between clear and set is visible on the flag in the single cycle after the qualifying edge.

// File: rtl/usbh_ad_pkg.sv
package usbh_ad_pkg;

    // Line state, encoded as {dp, dm}
    typedef enum logic [1:0] {
        LN_SE0   = 2'b00,
        LN_DM_HI = 2'b01,
        LN_DP_HI = 2'b10,
        LN_SE1   = 2'b11
    } line_t;

    typedef enum logic {
        SPD_LOW  = 1'b0,
        SPD_FULL = 1'b1
    } speed_t;

    // Index of each interrupt flag in the flag vector
    localparam int FLG_CONN = 0;
    localparam int FLG_WAKE = 1;
    localparam int NFLAGS   = 2;

    typedef struct packed {
        logic   conn;
        speed_t speed;
    } link_t;

    // ceil(2.5 us * hz) = ceil(hz * 5 / 2e6)
    function automatic int unsigned qual_cycles(input longint unsigned hz);
        longint unsigned n;
        n = (hz * 5 + 64'd1999999) / 64'd2000000;
        return int'(n);
    endfunction

    function automatic logic one_high(input line_t ln);
        return (ln == LN_DP_HI) || (ln == LN_DM_HI);
    endfunction

endpackage

// File: rtl/usbh_ad_sync.sv
module usbh_ad_sync
    import usbh_ad_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  dp_i,
    input  logic  dm_i,
    output line_t line_o,
    output logic  change_o
);
    localparam int LAST = STAGES - 1;

    logic [1:0] stg [STAGES];
    line_t      line_d;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stg[g] <= 2'b00;
                    else       stg[g] <= {dp_i, dm_i};
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stg[g] <= 2'b00;
                    else       stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign line_o = line_t'(stg[LAST]);

    always_ff @(posedge clk_i) begin
        if (rst_i) line_d <= LN_SE0;
        else       line_d <= line_o;
    end

    assign change_o = (line_o != line_d);

endmodule

// File: rtl/usbh_ad_qtimer.sv
module usbh_ad_qtimer #(
    parameter int unsigned THRESH = 313
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic hold_i,
    input  logic run_i,
    input  logic restart_i,
    output logic done_o
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        if (restart_i)          cnt_nx = ONE;
        else if (cnt_q == LIMIT) cnt_nx = cnt_q;
        else                    cnt_nx = cnt_q + ONE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i || !run_i) cnt_q <= '0;
        else                           cnt_q <= cnt_nx;
    end

    assign done_o = run_i && !hold_i && (cnt_nx == LIMIT) && (cnt_q != LIMIT);

    assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LIMIT);

    assert_hold_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> (cnt_q == '0));

endmodule

// File: rtl/usbh_ad_flag.sv
module usbh_ad_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic srst_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || srst_i) flag_q <= 1'b0;
        else if (set_i)      flag_q <= 1'b1;
        else if (clr_i)      flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_i;

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (set_i && !srst_i) |=> flag_o);

    assert_clr_works_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/usbh_attach_detect.sv
module usbh_attach_detect
    import usbh_ad_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 125_000_000,
    parameter int              SYNC_FF = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic soft_rst_i,
    input  logic dp_i,
    input  logic dm_i,
    input  logic suspend_i,
    input  logic conn_ie_i,
    input  logic wake_ie_i,
    input  logic conn_clr_i,
    input  logic wake_clr_i,
    output logic conn_o,
    output logic speed_o,
    output logic conn_flag_o,
    output logic wake_flag_o,
    output logic conn_irq_o,
    output logic wake_irq_o
);
    localparam int unsigned THRESH = qual_cycles(CLK_HZ);

    line_t line;
    logic  line_chg;
    link_t link_q;
    logic  att_run, det_run, att_done, det_done;

    logic [NFLAGS-1:0] flg_set, flg_clr, flg_en, flg_val, flg_irq;

    usbh_ad_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .dp_i     (dp_i),
        .dm_i     (dm_i),
        .line_o   (line),
        .change_o (line_chg)
    );

    assign att_run = !link_q.conn && one_high(line);
    assign det_run =  link_q.conn && (line == LN_SE0);

    usbh_ad_qtimer #(.THRESH(THRESH)) u_att_tmr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .hold_i    (soft_rst_i),
        .run_i     (att_run),
        .restart_i (line_chg),
        .done_o    (att_done)
    );

    usbh_ad_qtimer #(.THRESH(THRESH)) u_det_tmr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .hold_i    (soft_rst_i),
        .run_i     (det_run),
        .restart_i (line_chg),
        .done_o    (det_done)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            link_q <= '{conn: 1'b0, speed: SPD_LOW};
        end else if (att_done) begin
            link_q.conn  <= 1'b1;
            link_q.speed <= (line == LN_DP_HI) ? SPD_FULL : SPD_LOW;
        end else if (det_done) begin
            link_q.conn  <= 1'b0;
        end
    end

    assign flg_set[FLG_CONN] = att_done;
    assign flg_set[FLG_WAKE] = att_done && suspend_i;
    assign flg_clr = {wake_clr_i, conn_clr_i};
    assign flg_en  = {wake_ie_i, conn_ie_i};

    generate
        for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
            usbh_ad_flag u_flag (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .srst_i (soft_rst_i),
                .set_i  (flg_set[f]),
                .clr_i  (flg_clr[f]),
                .en_i   (flg_en[f]),
                .flag_o (flg_val[f]),
                .irq_o  (flg_irq[f])
            );
        end
    endgenerate

    assign conn_o      = link_q.conn;
    assign speed_o     = link_q.speed;
    assign conn_flag_o = flg_val[FLG_CONN];
    assign wake_flag_o = flg_val[FLG_WAKE];
    assign conn_irq_o  = flg_irq[FLG_CONN];
    assign wake_irq_o  = flg_irq[FLG_WAKE];

    assert_attach_cause_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(conn_o) |-> $past(one_high(line)));

    assert_detach_cause_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(conn_o) |-> $past(line == LN_SE0));

    assert_speed_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (conn_o && $past(conn_o)) |-> $stable(speed_o));

    assert_irq_gate_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        conn_irq_o |-> (conn_ie_i && conn_flag_o));

    assert_wake_pair_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wake_flag_o) |-> conn_flag_o);

    assert_soft_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        soft_rst_i |=> (!conn_flag_o && !wake_flag_o && $stable(conn_o)));

endmodule

// File: tb/usbh_attach_detect_tb.sv
module usbh_attach_detect_tb;

    localparam real CLK_HZ_R = 125.0e6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst = 1'b0;
    logic dp = 1'b0, dm = 1'b0, susp = 1'b0;
    logic conn_ie = 1'b0, wake_ie = 1'b0, conn_clr = 1'b0, wake_clr = 1'b0;
    logic conn, speed, conn_flag, wake_flag, conn_irq, wake_irq;

    int checks = 0;
    int errors = 0;
    int thr;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    usbh_attach_detect #(.CLK_HZ(125_000_000)) u_dut (
        .clk_i(clk), .rst_i(rst), .soft_rst_i(soft_rst),
        .dp_i(dp), .dm_i(dm), .suspend_i(susp),
        .conn_ie_i(conn_ie), .wake_ie_i(wake_ie),
        .conn_clr_i(conn_clr), .wake_clr_i(wake_clr),
        .conn_o(conn), .speed_o(speed),
        .conn_flag_o(conn_flag), .wake_flag_o(wake_flag),
        .conn_irq_o(conn_irq), .wake_irq_o(wake_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic lines(input logic p, input logic m);
        dp = p;
        dm = m;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        conn_clr = 1'b1; wake_clr = 1'b1;
        wait_n(1);
        conn_clr = 1'b0; wake_clr = 1'b0;
    endtask

    task automatic force_detach();
        lines(0, 0);
        wait_n(thr + 6);
    endtask

    task automatic force_attach(input logic p);
        lines(p, ~p);
        wait_n(thr + 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        thr = $rtoi($ceil(2.5e-6 * CLK_HZ_R));
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R9: reset state
        check("R9 conn", conn, 0);
        check("R9 speed", speed, 0);
        check("R9 conn_flag", conn_flag, 0);
        check("R9 wake_flag", wake_flag, 0);

        // R1 R2 R5: attach pulse sweep around the threshold, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            for (int n = thr - 3; n <= thr + 2; n++) begin
                force_detach();
                pulse_clr();
                lines(pol[0], ~pol[0]);
                wait_n(n);
                lines(0, 0);
                wait_n(4);
                check("R1 attach len", conn, n >= thr);
                if (n >= thr) check("R2 speed", speed, pol[0]);
                check("R5 conn_flag", conn_flag, n >= thr);
                check("R6 no wake unsuspended", wake_flag, 0);
            end
        end

        // R1: exact cycle of the rise (edge THRESH+1 after the drive)
        force_detach();
        lines(1, 0);
        wait_n(thr + 1);
        check("R1 not yet", conn, 0);
        wait_n(1);
        check("R1 rise edge", conn, 1);

        // R3 R10: detach pulse sweep
        for (int n = thr - 3; n <= thr + 2; n++) begin
            force_attach(1'b1);
            pulse_clr();
            lines(0, 0);
            wait_n(n);
            lines(1, 0);
            wait_n(4);
            check("R3 detach len", conn, n < thr);
            check("R10 detach no flag", conn_flag, 0);
        end

        // R4: one-cycle break restarts the count
        force_detach();
        lines(1, 0); wait_n(thr - 5);
        lines(0, 0); wait_n(1);
        lines(1, 0); wait_n(thr - 5);
        lines(0, 0); wait_n(4);
        check("R4 break", conn, 0);
        // R4: polarity swap restarts the count
        lines(1, 0); wait_n(thr - 5);
        lines(0, 1); wait_n(thr - 5);
        lines(0, 0); wait_n(4);
        check("R4 swap short", conn, 0);
        lines(1, 0); wait_n(thr - 5);
        lines(0, 1); wait_n(thr);
        lines(0, 0); wait_n(4);
        check("R4 swap full", conn, 1);
        check("R2 low speed", speed, 0);

        // R10: both lines high never qualifies
        force_detach();
        lines(1, 1); wait_n(2 * thr);
        check("R10 SE1 no attach", conn, 0);
        force_attach(1'b1);
        lines(1, 1); wait_n(2 * thr);
        check("R10 SE1 no detach", conn, 1);

        // R5: interrupt gating
        force_detach();
        pulse_clr();
        force_attach(1'b1);
        conn_ie = 1'b0; wait_n(1);
        check("R5 irq off", conn_irq, 0);
        conn_ie = 1'b1; wait_n(1);
        check("R5 irq on", conn_irq, 1);
        // R7: write one to clear
        conn_clr = 1'b1; wait_n(1); conn_clr = 1'b0;
        check("R7 clear", conn_flag, 0);
        check("R5 irq after clear", conn_irq, 0);

        // R6: attach while suspended
        force_detach();
        pulse_clr();
        susp = 1'b1;
        force_attach(1'b0);
        susp = 1'b0;
        check("R6 wake flag", wake_flag, 1);
        check("R6 conn flag", conn_flag, 1);
        wake_ie = 1'b0; wait_n(1);
        check("R6 wake irq off", wake_irq, 0);
        wake_ie = 1'b1; wait_n(1);
        check("R6 wake irq on", wake_irq, 1);
        wake_clr = 1'b1; wait_n(1); wake_clr = 1'b0;
        check("R7 wake clear", wake_flag, 0);

        // R7: set wins over a same-cycle clear
        force_detach();
        lines(1, 0);
        conn_clr = 1'b1;
        wait_n(thr + 1);
        check("R7 cleared before set", conn_flag, 0);
        wait_n(1);
        conn_clr = 1'b0;
        check("R7 set wins", conn_flag, 1);
        check("R7 conn", conn, 1);

        // R8: soft reset clears flags, keeps status
        wait_n(2);
        soft_rst = 1'b1; wait_n(1); soft_rst = 1'b0;
        check("R8 flag cleared", conn_flag, 0);
        check("R8 conn kept", conn, 1);
        check("R8 speed kept", speed, 1);
        // R8: timers frozen while held, restart after release
        force_detach();
        soft_rst = 1'b1;
        lines(0, 1);
        wait_n(2 * thr);
        check("R8 frozen", conn, 0);
        soft_rst = 1'b0;
        wait_n(thr - 1);
        check("R8 restart early", conn, 0);
        wait_n(2);
        check("R8 restart done", conn, 1);
        check("R8 speed low", speed, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule